// File: doc/BRIEF.md
# Event-Counting One-Shot Down Timer

This block is a down counter that runs from one of two tick sources. In interval mode it steps down on every clock. In event mode it steps down once for each falling edge seen on an external pin. The pin is asynchronous, so it passes through a synchronizer chain before an edge detector looks at it.

Firmware starts a run in two byte writes. The first write parks the low byte in a holding latch. The second write supplies the high byte, which moves the whole word into the counter and arms the timer. When the armed counter is ticked while it holds zero, the block raises a sticky interrupt flag and disarms itself. The counter then wraps to all ones and keeps counting, but it cannot raise the flag again until the next high-byte write. Reading the low byte acknowledges the flag.

Address decoding and interrupt masking belong to the surrounding logic. Here they appear only as a one-bit byte select, read and write strobes, and a raw flag output.

Top module: `evt_oneshot_timer`

## Requirements
- R1: A write with `byte_sel`=0 (low byte) stores `wr_data` in a holding latch only. The counter value seen on `rd_data` does not change because of it.
- R2: A write with `byte_sel`=1 (high byte) loads the counter with {`wr_data`, latched low byte} at that clock edge. The same write arms the timer and clears `irq_flag`.
- R3: With `count_events`=0 the counter decrements by one on every clock edge that is not a load. A value N loaded at edge L reads N-k after edge L+k.
- R4: With `count_events`=1 the counter decrements by one for each falling edge of `pulse_in`. The decrement lands on the third clock edge after the pin falls: two synchronizer stages, then the edge stage.
- R5: When the counter is ticked while it holds zero and the timer is armed, `irq_flag` is set at that edge. In interval mode this means a load of N raises the flag N+1 clocks after the load edge.
- R6: The flag fires only once per arming. After a timeout the counter wraps to all ones and keeps counting, and further passes through zero leave the flag clear until the next high-byte write.
- R7: A read strobe with `byte_sel`=0 clears `irq_flag` at that edge. A read strobe with `byte_sel`=1 leaves it unchanged.
- R8: If a timeout and a low-byte read fall on the same edge, the flag ends up set.
- R9: After reset the counter is 0, the holding latch is 0, the timer is disarmed and `irq_flag` is 0. An unarmed counter passing through zero does not set the flag.
- R10: `rd_data` shows counter bits [7:0] when `byte_sel`=0 and bits [15:8] when `byte_sel`=1. It is combinational and needs no read strobe.
- R11: In event mode, rising edges and a steady level on `pulse_in` leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; interval ticks and all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_events | input | 1 | Mode bit: 0 interval timing, 1 falling-edge counting |
| pulse_in | input | 1 | Asynchronous event pin |
| wr_en | input | 1 | Write strobe for the byte chosen by byte_sel |
| rd_en | input | 1 | Read strobe; a low-byte read acknowledges the flag |
| byte_sel | input | 1 | 0 selects the low byte, 1 the high byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected counter byte |
| irq_flag | output | 1 | Sticky timeout flag |

## Verification
The assertions assume that `wr_en` and `rd_en` are never raised together, and that `count_events` only changes between runs. The stimulus holds to both by driving one strobe for a single clock and changing the mode only while no timing check is pending. The edge assertions also assume that each level of `pulse_in` lasts at least two clocks, so that every edge reaches the synchronizer. The bench holds each level for three clocks.

// File: rtl/evtm_pkg.sv
package evtm_pkg;
  // byte lane chosen by byte_sel
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } evtm_byte_e;

  // tick source chosen by count_events
  typedef enum logic {
    SRC_CLOCK = 1'b0,
    SRC_EDGE  = 1'b1
  } evtm_src_e;
endpackage

// File: rtl/evtm_edge_sync.sv
module evtm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  // pipe[0..STAGES-1] synchronize, pipe[STAGES] holds previous level
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= 1'b1;
    else        pipe[0] <= pin_i;
  end

  genvar gi;
  generate
    for (gi = 1; gi <= STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[gi] <= 1'b1;
        else        pipe[gi] <= pipe[gi-1];
      end
    end
  endgenerate

  function automatic logic is_fall(input logic prev, input logic now);
    return prev & ~now;
  endfunction

  assign fall_o = is_fall(pipe[STAGES], pipe[STAGES-1]);

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R4
endmodule

// File: rtl/evtm_down_counter.sv
module evtm_down_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  input  logic                  tick_i,
  output logic [2*BYTE_W-1:0]   cnt_o,
  output logic                  load_o,
  output logic                  timeout_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [BYTE_W-1:0] lo_hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic at_zero(input logic [CNT_W-1:0] v);
    return (v == '0);
  endfunction

  assign load_o    = wr_hi_i;
  assign timeout_o = armed_q & tick_i & at_zero(cnt_q) & ~load_o;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_hold_q <= '0;
    else if (wr_lo_i) lo_hold_q <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_o) cnt_q <= {wr_data_i, lo_hold_q};
    else if (tick_i) cnt_q <= step_down(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (load_o)    armed_q <= 1'b1;
    else if (timeout_o) armed_q <= 1'b0;
  end

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> armed_q); // R2
  AST_DISARM_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !armed_q); // R6
  AST_WRAP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (&cnt_q)); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_o) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/evtm_irq_flag.sv
module evtm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_load_i,
  input  logic clr_read_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag_q <= 1'b0;
    else if (set_i)                    flag_q <= 1'b1;
    else if (clr_load_i || clr_read_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R8
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_i)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_read_i && !set_i) |=> !flag_q); // R7
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_load_i && !set_i) |=> !flag_q); // R2
endmodule

// File: rtl/evt_oneshot_timer.sv
module evt_oneshot_timer #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_events,
  input  logic              pulse_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              byte_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_flag
);
  import evtm_pkg::*;

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // named internal events
  logic             edge_fall;
  logic             tick;
  logic             wr_lo, wr_hi, rd_lo;
  logic             load_ev, timeout_ev;
  logic [CNT_W-1:0] cnt;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                  input evtm_byte_e lane);
    return (lane == SEL_HI) ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  assign wr_lo = wr_en & (evtm_byte_e'(byte_sel) == SEL_LO);
  assign wr_hi = wr_en & (evtm_byte_e'(byte_sel) == SEL_HI);
  assign rd_lo = rd_en & (evtm_byte_e'(byte_sel) == SEL_LO);

  evtm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pulse_in),
    .fall_o (edge_fall)
  );

  assign tick = (evtm_src_e'(count_events) == SRC_EDGE) ? edge_fall : 1'b1;

  evtm_down_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wr_data_i (wr_data),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .load_o    (load_ev),
    .timeout_o (timeout_ev)
  );

  evtm_irq_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (timeout_ev),
    .clr_load_i (load_ev),
    .clr_read_i (rd_lo),
    .flag_o     (irq_flag)
  );

  assign rd_data = pick_byte(cnt, evtm_byte_e'(byte_sel));

  AST_TIMED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_events && !load_ev) |=> (cnt == ($past(cnt) - ONE))); // R3
  AST_LOW_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !tick) |=> $stable(cnt)); // R1
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R7
endmodule

// File: tb/evt_oneshot_timer_tb.sv
`timescale 1ns/1ps
module evt_oneshot_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_events = 1'b1;
  logic       pulse_in = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, byte_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_flag;
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  evt_oneshot_timer u_dut (
    .clk(clk), .rst_n(rst_n), .count_events(count_events), .pulse_in(pulse_in),
    .wr_en(wr_en), .rd_en(rd_en), .byte_sel(byte_sel), .wr_data(wr_data),
    .rd_data(rd_data), .irq_flag(irq_flag)
  );

  // {load value, sample offset k}
  localparam logic [31:0] VEC [6] = '{
    {16'd0,   16'd0},
    {16'd1,   16'd1},
    {16'd7,   16'd3},
    {16'd40,  16'd20},
    {16'd300, 16'd299},
    {16'h0100, 16'd17}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    byte_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel);
    byte_sel = sel; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr(1'b0, v[7:0]);
    wr(1'b1, v[15:8]);
  endtask

  task automatic get_cnt(output logic [15:0] v);
    byte_sel = 1'b0; #0.1; v[7:0] = rd_data;
    byte_sel = 1'b1; #0.1; v[15:8] = rd_data;
    byte_sel = 1'b0;
  endtask

  task automatic fall_and_rise(input logic [15:0] exp_after);
    logic [15:0] v;
    pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    get_cnt(v);
    chk("R4 count after falling edge", v, exp_after);
    pulse_in = 1'b1;
    repeat (3) @(negedge clk);
    get_cnt(v);
    chk("R11 rising edge ignored", v, exp_after);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    get_cnt(v);
    chk("R9 counter after reset", v, 16'h0000);
    chk("R9 flag after reset", irq_flag, 1'b0);
    count_events = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 unarmed pass through zero", irq_flag, 1'b0);

    // timed vectors: R3, R5, R2
    for (int i = 0; i < 6; i++) begin
      logic [15:0] n, k;
      int j;
      n = VEC[i][31:16];
      k = VEC[i][15:0];
      load(n);
      chk("R2 load clears flag", irq_flag, 1'b0);
      j = 0;
      while (j < k) begin @(negedge clk); j++; end
      get_cnt(v);
      chk("R3 timed count", v, n - k);
      while (!irq_flag && j < n + 5) begin @(negedge clk); j++; end
      chk("R5 timeout delay", j, n + 1);
    end

    // R7 read high keeps, read low clears
    rd(1'b1);
    chk("R7 high read keeps flag", irq_flag, 1'b1);
    rd(1'b0);
    chk("R7 low read clears flag", irq_flag, 1'b0);

    // R6 one-shot: no refire after wrap
    repeat (65600) @(negedge clk);
    chk("R6 no second timeout", irq_flag, 1'b0);

    // R8 timeout and low read on same edge
    load(16'd5);
    repeat (5) @(negedge clk);
    rd(1'b0);
    chk("R8 set wins over read clear", irq_flag, 1'b1);

    // event mode
    count_events = 1'b1;
    load(16'hA55A);
    get_cnt(v);
    chk("R2 high write loads word", v, 16'hA55A);
    byte_sel = 1'b0; #0.1;
    chk("R10 low lane", rd_data, 8'h5A);
    byte_sel = 1'b1; #0.1;
    chk("R10 high lane", rd_data, 8'hA5);
    wr(1'b0, 8'h11);
    get_cnt(v);
    chk("R1 low write leaves counter", v, 16'hA55A);
    repeat (4) @(negedge clk);
    get_cnt(v);
    chk("R11 steady pin holds counter", v, 16'hA55A);
    wr(1'b1, 8'h00);
    get_cnt(v);
    chk("R2 latched low byte used", v, 16'h0011);

    load(16'd2);
    fall_and_rise(16'd1);
    fall_and_rise(16'd0);
    chk("R5 no flag before zero tick", irq_flag, 1'b0);
    fall_and_rise(16'hFFFF);
    chk("R5 flag on edge at zero", irq_flag, 1'b1);
    rd(1'b0);
    fall_and_rise(16'hFFFE);
    chk("R6 no refire in event mode", irq_flag, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule